// File: doc/BRIEF.md
# Lockable General-Purpose I/O Port

This block is a sixteen-pin general-purpose I/O port on a simple register bus. A base register, written through a separate configuration strobe, places an eight-word register window anywhere in a 16-bit address space. Software can set each pin as an input or an output. An output can be push-pull or open-drain, and an input can have an internal pull-up. The block drives per-pin output-enable, output-value and pull-up controls toward the pad ring. It samples the pads through a two-stage synchronizer.

Software writes a pin's lock bit to freeze that pin's direction, drive type and pull-up setting. Only a reset clears a lock. Writes to a locked setting are dropped without notice. The output data register and the input data register never lock.

Register window (word offset = `bus_addr[2:0]`): 0 output data, 1 input data (read-only), 2 direction (1 = output), 3 drive type (1 = open-drain), 4 pull-up enable (1 = on), 5 lock (write 1 to set). Offsets 6 and 7 read as zero. Bit i of every register belongs to pin i.

Top module: `gpio_lock_port`

## Requirements
- R1: Reset clears every pin's settings: direction is input, drive type is push-pull, pull-up is off and the lock is clear. Output data is cleared. `pad_oe`, `pad_out` and `pad_pu` are all zero. The base register returns to its parameter value (default 0x0300).
- R2: The port responds only when `bus_addr[15:3]` equals `base[15:3]`. The base register ignores the low three bits of a value written to it. A write outside the window changes nothing, and a read outside the window returns 0.
- R3: A pin whose direction bit is 0 never drives: its `pad_oe` and `pad_out` are 0. A push-pull output pin has `pad_oe`=1 and `pad_out` equal to its output data bit.
- R4: An open-drain output pin always has `pad_out`=0. Its `pad_oe` is 1 when its data bit is 0. When its data bit is 1, `pad_oe` is 0 and the pin is released.
- R5: `pad_pu` of a pin is 1 only when its pull-up bit is 1 and the pin is an input.
- R6: Writing the lock register sets each lock bit that has a 1 in the write data. A lock bit is never cleared except by reset.
- R7: A write to the direction, drive-type or pull-up register leaves locked pins' bits unchanged and updates unlocked pins' bits in the same write.
- R8: Locks do not affect the output data register.
- R9: Reading the input data register returns the pad values of all pins, including outputs, after a two-flop synchronizer. A pad change made just before clock edge k first shows in data captured by a read at edge k+2.
- R10: A read strobe at an edge loads `bus_rdata` at that edge. Offsets 0 and 2 to 5 read back the stored registers. `bus_rdata` holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_wr | input | 1 | Load strobe for the base register |
| cfg_base_data | input | 16 | New base address (low 3 bits ignored) |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin driven value |
| pad_pu | output | 16 | Per-pin pull-up enable |

## Verification
The bound checker tests on every cycle that input pins never drive and that open-drain pins never drive high or drive while released. It also tests that pull-ups follow only input pins, that lock bits never fall and that locked settings never change, and that an input-data read returns the synchronizer output. Other behaviour shows only in the bench's scenarios. These include the exact pad pattern for each mix of settings, the address decode after the base moves, and a partial write that updates some pins and not others. They also include the two-edge synchronizer delay and the return to defaults after reset.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_DOUT = 3'd0,
    OFS_DIN  = 3'd1,
    OFS_DIR  = 3'd2,
    OFS_DRV  = 3'd3,
    OFS_PULL = 3'd4,
    OFS_LOCK = 3'd5
  } gpio_ofs_e;

  // Output enable of one pin: outputs drive, except open-drain pins holding 1.
  function automatic logic pin_oe(input logic is_out, input logic is_od, input logic d);
    return is_out & (~is_od | ~d);
  endfunction

  // Driven level of one pin: open-drain pins only ever drive low.
  function automatic logic pin_level(input logic is_out, input logic is_od, input logic d);
    return is_out & ~is_od & d;
  endfunction

  // Pull-up applies to input pins only.
  function automatic logic pin_pull(input logic is_out, input logic pu_en);
    return pu_en & ~is_out;
  endfunction

  // Lock-aware update of one configuration bit.
  function automatic logic guarded_bit(input logic cur, input logic nxt, input logic we,
                                       input logic locked);
    return (we & ~locked) ? nxt : cur;
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_lock_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] BASE_RESET = 16'h0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_data,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= BASE_RESET[ADDR_W-1:OFS_W];
    else if (base_wr) page_q <= base_data[ADDR_W-1:OFS_W];
  end

  assign hit = (addr[ADDR_W-1:OFS_W] == page_q);
  assign ofs = addr[OFS_W-1:0];
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_lock_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_dout,
  input  logic            we_dir,
  input  logic            we_drv,
  input  logic            we_pull,
  input  logic            we_lock,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dout_q,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] drv_q,
  output logic [PINS-1:0] pull_q,
  output logic [PINS-1:0] lock_q
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dout_q[i] <= 1'b0;
        dir_q[i]  <= 1'b0;
        drv_q[i]  <= 1'b0;
        pull_q[i] <= 1'b0;
        lock_q[i] <= 1'b0;
      end else begin
        if (we_dout) dout_q[i] <= wdata[i];
        dir_q[i]  <= guarded_bit(dir_q[i],  wdata[i], we_dir,  lock_q[i]);
        drv_q[i]  <= guarded_bit(drv_q[i],  wdata[i], we_drv,  lock_q[i]);
        pull_q[i] <= guarded_bit(pull_q[i], wdata[i], we_pull, lock_q[i]);
        lock_q[i] <= lock_q[i] | (we_lock & wdata[i]);
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] d,
  output logic [PINS-1:0] q
);
  logic [PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else         stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_lock_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] drv_q,
  input  logic [PINS-1:0] pull_q,
  input  logic [PINS-1:0] dout_q,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_pu
);
  for (genvar i = 0; i < PINS; i++) begin : g_pad
    assign pad_oe[i]  = pin_oe(dir_q[i], drv_q[i], dout_q[i]);
    assign pad_out[i] = pin_level(dir_q[i], drv_q[i], dout_q[i]);
    assign pad_pu[i]  = pin_pull(dir_q[i], pull_q[i]);
  end
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
  import gpio_lock_pkg::*;
#(
  parameter int          PINS        = 16,
  parameter int          ADDR_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] BASE_RESET  = 16'h0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_base_wr,
  input  logic [ADDR_W-1:0] cfg_base_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_pu
);
  logic             hit;
  logic [OFS_W-1:0] ofs;
  logic [PINS-1:0]  dout_q, dir_q, drv_q, pull_q, lock_q, sync_q;
  logic             wr_hit, rd_hit, rd_din;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .BASE_RESET(BASE_RESET)) u_dec (
    .clk(clk), .rst_n(rst_n), .base_wr(cfg_base_wr), .base_data(cfg_base_data),
    .addr(bus_addr), .hit(hit), .ofs(ofs)
  );

  assign wr_hit = bus_wr & hit;
  assign rd_hit = bus_rd & hit;
  assign rd_din = rd_hit & (ofs == OFS_DIN);

  gpio_cfg_bank #(.PINS(PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .we_dout(wr_hit & (ofs == OFS_DOUT)),
    .we_dir (wr_hit & (ofs == OFS_DIR)),
    .we_drv (wr_hit & (ofs == OFS_DRV)),
    .we_pull(wr_hit & (ofs == OFS_PULL)),
    .we_lock(wr_hit & (ofs == OFS_LOCK)),
    .wdata(bus_wdata),
    .dout_q(dout_q), .dir_q(dir_q), .drv_q(drv_q), .pull_q(pull_q), .lock_q(lock_q)
  );

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
  );

  gpio_pad_ctrl #(.PINS(PINS)) u_pad (
    .dir_q(dir_q), .drv_q(drv_q), .pull_q(pull_q), .dout_q(dout_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  logic [PINS-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (ofs)
        OFS_DOUT: rd_mux = dout_q;
        OFS_DIN:  rd_mux = sync_q;
        OFS_DIR:  rd_mux = dir_q;
        OFS_DRV:  rd_mux = drv_q;
        OFS_PULL: rd_mux = pull_q;
        OFS_LOCK: rd_mux = lock_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_lock_port_chk.sv
module gpio_lock_port_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] dir_q,
  input logic [PINS-1:0] drv_q,
  input logic [PINS-1:0] pull_q,
  input logic [PINS-1:0] lock_q,
  input logic [PINS-1:0] dout_q,
  input logic [PINS-1:0] sync_q,
  input logic            rd_din,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_pu,
  input logic [PINS-1:0] bus_rdata
);
  assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out) & ~dir_q) == '0);

  assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & drv_q) == '0);

  assert_od_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & drv_q & dout_q) == '0);

  assert_pull_inputs_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & dir_q) == '0);

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lock_q) & ~lock_q) == '0));

  assert_locked_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((((dir_q ^ $past(dir_q)) | (drv_q ^ $past(drv_q)) |
                (pull_q ^ $past(pull_q))) & $past(lock_q)) == '0));

  assert_din_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_din |=> (bus_rdata == $past(sync_q)));
endmodule

bind gpio_lock_port gpio_lock_port_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .drv_q(drv_q), .pull_q(pull_q),
  .lock_q(lock_q), .dout_q(dout_q), .sync_q(sync_q), .rd_din(rd_din),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .bus_rdata(bus_rdata)
);

// File: tb/sim_gpio_lock_port.sv
module sim_gpio_lock_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_base_wr = 1'b0;
  logic [15:0] cfg_base_data = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_oe, pad_out, pad_pu;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_lock_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base_wr(cfg_base_wr), .cfg_base_data(cfg_base_data),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu)
  );

  // dir, drive(1=open-drain), pull, dout  ->  expected oe, out, pu
  localparam logic [111:0] VEC [0:5] = '{
    {16'hFFFF, 16'h0000, 16'h0000, 16'hA5A5, 16'hFFFF, 16'hA5A5, 16'h0000},
    {16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF},
    {16'hFFFF, 16'hFFFF, 16'h0000, 16'h00FF, 16'hFF00, 16'h0000, 16'h0000},
    {16'h00FF, 16'h0F0F, 16'hFF00, 16'h3C3C, 16'h00F3, 16'h0030, 16'hFF00},
    {16'hF0F0, 16'hFF00, 16'h0F0F, 16'h5555, 16'hA0F0, 16'h0050, 16'h0F0F},
    {16'h1234, 16'h0000, 16'h0000, 16'hFFFF, 16'h1234, 16'h1234, 16'h0000}
  };

  logic [15:0] base = 16'h0300;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 16'h0);
    check("R1 pad_pu", pad_pu, 16'h0);
    rst_n = 1'b1;
    rd(base + 2, r); check("R1 dir", r, 16'h0);
    rd(base + 5, r); check("R1 lock", r, 16'h0);

    // R3 R4 R5 R10: vector table
    for (int k = 0; k < 6; k++) begin
      wr(base + 2, VEC[k][111:96]);
      wr(base + 3, VEC[k][95:80]);
      wr(base + 4, VEC[k][79:64]);
      wr(base + 0, VEC[k][63:48]);
      check("R3/R4 pad_oe", pad_oe, VEC[k][47:32]);
      check("R3/R4 pad_out", pad_out, VEC[k][31:16]);
      check("R5 pad_pu", pad_pu, VEC[k][15:0]);
      rd(base + 3, r); check("R10 drive readback", r, VEC[k][95:80]);
    end
    rd(base + 0, r); check("R10 dout readback", r, 16'hFFFF);
    @(negedge clk); check("R10 rdata held", bus_rdata, 16'hFFFF);
    rd(base + 6, r); check("R10 offset6 zero", r, 16'h0);

    // R2 base decode
    rd(16'h0402, r); check("R2 read outside window", r, 16'h0);
    wr(16'h0402, 16'hFFFF);
    rd(base + 2, r); check("R2 write outside ignored", r, 16'h1234);
    @(negedge clk); cfg_base_data = 16'h0C0B; cfg_base_wr = 1'b1;
    @(negedge clk); cfg_base_wr = 1'b0;
    base = 16'h0C08;
    rd(16'h0C0A, r); check("R2 moved base", r, 16'h1234);
    wr(16'h0302, 16'h0000);
    rd(16'h0C0A, r); check("R2 old base ignored", r, 16'h1234);

    // R6 R7 R8 locks
    wr(base + 2, 16'h0000); wr(base + 3, 16'h0000); wr(base + 4, 16'h0000);
    wr(base + 5, 16'h00FF);
    wr(base + 2, 16'hFFFF); wr(base + 3, 16'hFFFF); wr(base + 4, 16'hFFFF);
    rd(base + 2, r); check("R7 dir partial", r, 16'hFF00);
    rd(base + 3, r); check("R7 drive partial", r, 16'hFF00);
    rd(base + 4, r); check("R7 pull partial", r, 16'hFF00);
    wr(base + 5, 16'h0000);
    rd(base + 5, r); check("R6 lock not cleared", r, 16'h00FF);
    wr(base + 5, 16'hFF00);
    rd(base + 5, r); check("R6 lock accumulates", r, 16'hFFFF);
    wr(base + 2, 16'h0000);
    rd(base + 2, r); check("R7 dir frozen", r, 16'hFF00);
    check("R7 pads frozen oe", pad_oe, 16'h0000);
    wr(base + 0, 16'h1234);
    rd(base + 0, r); check("R8 dout under lock", r, 16'h1234);

    // R9 synchronizer latency and outputs included
    pad_in = 16'hBEEF;
    rd(base + 1, r); check("R9 not yet visible", r, 16'h0000);
    @(negedge clk);
    rd(base + 1, r); check("R9 visible after two edges", r, 16'hBEEF);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 pads after reset", pad_oe | pad_out | pad_pu, 16'h0);
    rst_n = 1'b1;
    base = 16'h0300;
    rd(base + 5, r); check("R1 lock cleared", r, 16'h0);
    rd(base + 2, r); check("R1 base restored dir", r, 16'h0);
    finish_run();
  end
endmodule